// File: doc/BRIEF.md
# Answer-to-Reset Bit Streamer

This block produces a fixed identification word, one bit per serial clock, when a card reset pulse is applied to a selected device. It runs on the chip's system clock. The reset pin, the active-low select, the serial clock and a write-busy flag from the memory controller pass through small synchronizers. Edges are detected on the synchronized levels. The streamer then drives a data bit and an output-enable, which a pad wrapper turns into an open-drain or tri-state line.

A pulse is accepted only when its rising edge occurs while the device is selected and no nonvolatile write is running. Acceptance raises a one-cycle stop request so that the serial protocol engine drops any transaction in progress. Streaming begins when the reset line falls again. Byte 0 goes out first and each byte is sent least significant bit first. Every falling edge of the serial clock advances one bit, and the word repeats for as long as clocking continues. Deselection or a starting write ends the stream at once.

Top module: `atr_streamer`

## Requirements
- R1: During and right after the synchronous reset, `sd_oe`, `sd_out` and `xact_stop` are all low.
- R2: A reset pulse (high, then low) on `card_rst` with `sel_n` low and `wr_busy` low asserts `sd_oe` after the falling edge. While `card_rst` is still high, `sd_oe` stays low.
- R3: Stream bit n equals `ATR_WORD[n]`, where byte k of the word sits in bits [8k+7:8k]. This sends byte 0 first, LSB first. For the default `32'h55AA0119` the first eight bits are 1,0,0,1,1,0,0,0.
- R4: `sd_out` changes only after a falling edge of `sclk`. A rising edge leaves it unchanged. Clocks given before a stream is armed have no effect.
- R5: After the last bit of the word, the next falling edge presents bit 0 again, and this continues without limit. This also holds for word lengths that are not a power of two.
- R6: `sel_n` going high, whether the pulse is pending or the stream is running, drops `sd_oe` and returns the block to idle. Selecting the device again does not resume the stream without a new pulse.
- R7: A reset pulse whose rising edge happens while the device is deselected is ignored.
- R8: A reset pulse that rises while `wr_busy` is high starts nothing and raises no `xact_stop`. `wr_busy` going high during a stream ends it.
- R9: Each accepted rising edge of `card_rst` gives exactly one single-cycle pulse on `xact_stop`.
- R10: A new accepted pulse during a stream drops `sd_oe` while `card_rst` is high. The stream then restarts at bit 0 after the falling edge.
- R11: `sd_out` is low whenever `sd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_rst | input | 1 | Card reset pin level (asynchronous) |
| sel_n | input | 1 | Chip select, active low (asynchronous) |
| sclk | input | 1 | Serial clock pin level (asynchronous) |
| wr_busy | input | 1 | High while a nonvolatile write cycle runs |
| sd_out | output | 1 | Current stream bit, low when not driving |
| sd_oe | output | 1 | Output enable for the data pad |
| xact_stop | output | 1 | One-cycle request to abort the bus transaction |

## Verification
The bench builds two copies of the block side by side. The first uses the default four-byte word, which has a 32-bit wrap where the 5-bit index rolls over naturally. The second uses a three-byte word, which forces the compare-based wrap at bit 23 and exercises the byte-select guard against the unused fourth byte slot. Both copies get the same stimulus. The stream is followed through more than two full periods of the longer word, and every bit is compared with the word parameter indexed modulo its length. The abort, blocking and restart paths are then driven in turn at the same pins.

// File: rtl/atr_pkg.sv
// Shared types and line numbering for the answer-to-reset streamer.
package atr_pkg;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_STREAM = 2'd2
    } atr_state_e;

    // Positions of the synchronized pin lines inside the sampler vector.
    localparam int unsigned LINE_CRST  = 0;
    localparam int unsigned LINE_SEL   = 1;
    localparam int unsigned LINE_SCLK  = 2;
    localparam int unsigned LINE_BUSY  = 3;
    localparam int unsigned NUM_LINES  = 4;

endpackage

// File: rtl/atr_edge_sync.sv
// Synchronizes N asynchronous lines into the clk domain and flags their edges.
// Assumes: STAGES >= 2. Every line resets to 0, so active-low pins must be
// inverted before they reach this module.
module atr_edge_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0][STAGES-1:0] chain;
    logic [N-1:0]             lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        // Shift each raw line through its own synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[g][STAGES-1];
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/atr_bit_index.sv
// Bit position counter of the stream. Load clears it, step advances it, and
// it wraps after WORD_BITS-1. A power-of-two length wraps by overflow; any
// other length uses a compare.
module atr_bit_index #(
    parameter int unsigned WORD_BITS = 32,
    localparam int unsigned IW       = $clog2(WORD_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST = IW'(WORD_BITS - 1);

    logic [IW-1:0] idx_nxt;

    if ((1 << IW) == WORD_BITS) begin : g_pow2
        assign idx_nxt = idx + 1'b1;
    end else begin : g_cmp
        assign idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
    end

    // Hold, clear or advance the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= '0;
        else if (step) idx <= idx_nxt;
    end

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == LAST && step && !load) |=> (idx == '0));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(idx));

endmodule

// File: rtl/atr_bit_select.sv
// Picks the stream bit at position idx from the identification word. The byte
// is chosen by the upper index bits and the bit inside it LSB first.
// Assumes: BYTES >= 2. Byte k of WORD sits in bits [8k+7:8k].
module atr_bit_select #(
    parameter int unsigned             BYTES = 4,
    parameter logic [8*BYTES-1:0]      WORD  = '0,
    localparam int unsigned            IW    = $clog2(8 * BYTES),
    localparam int unsigned            BW    = IW - 3
) (
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic          bit_o
);

    logic [7:0]    byte_tbl [BYTES];
    logic [BW-1:0] byte_sel;
    logic [2:0]    bit_sel;
    logic [7:0]    cur_byte;

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign byte_tbl[g] = WORD[8*g +: 8];
    end

    assign byte_sel = idx[IW-1:3];
    assign bit_sel  = idx[2:0];

    // Select the current byte, guarding slots past the last real byte.
    always_comb begin
        cur_byte = 8'h00;
        if (int'(byte_sel) < BYTES) cur_byte = byte_tbl[byte_sel];
    end

    assign bit_o = en & cur_byte[bit_sel];

endmodule

// File: rtl/atr_ctrl.sv
// Arming and streaming controller. A reset rise while the device is selected
// and not busy arms the block and requests a transaction stop. The reset fall
// starts the stream, and serial-clock falls advance it. Deselection or write
// busy returns the block to idle.
// Assumes: all inputs are synchronized single-cycle edges or levels.
module atr_ctrl
    import atr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crst_rise,
    input  logic crst_fall,
    input  logic sel_act,
    input  logic sclk_fall,
    input  logic busy,
    output logic load,
    output logic step,
    output logic streaming,
    output logic xact_stop
);

    atr_state_e state, state_nxt;
    logic       stop_req;
    logic       accept;

    assign accept = crst_rise & sel_act & ~busy;

    // Work out the next state and the counter controls.
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        step      = 1'b0;
        stop_req  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = ST_ARMED;
                    stop_req  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (!sel_act || busy) begin
                    state_nxt = ST_IDLE;
                end else if (crst_fall) begin
                    state_nxt = ST_STREAM;
                    load      = 1'b1;
                end
            end
            ST_STREAM: begin
                if (!sel_act || busy) begin
                    state_nxt = ST_IDLE;
                end else if (crst_rise) begin
                    state_nxt = ST_ARMED;
                    stop_req  = 1'b1;
                end else if (sclk_fall) begin
                    step = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Register the state and the stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            xact_stop <= 1'b0;
        end else begin
            state     <= state_nxt;
            xact_stop <= stop_req;
        end
    end

    assign streaming = (state == ST_STREAM);

    // R6
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (state == ST_IDLE));

    // R8
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state == ST_IDLE));

    // R9
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xact_stop |=> !xact_stop);

endmodule

// File: rtl/atr_streamer.sv
// Top of the answer-to-reset streamer. It synchronizes the pin inputs, runs
// the controller and puts the selected word bit on the data output.
// Assumes: ATR_BYTES >= 2, SYNC_STAGES >= 2, and serial-clock phases longer
// than SYNC_STAGES+1 system clocks.
module atr_streamer
    import atr_pkg::*;
#(
    parameter int unsigned              ATR_BYTES   = 4,
    parameter logic [8*ATR_BYTES-1:0]   ATR_WORD    = 32'h55AA0119,
    parameter int unsigned              SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic sel_n,
    input  logic sclk,
    input  logic wr_busy,
    output logic sd_out,
    output logic sd_oe,
    output logic xact_stop
);

    localparam int unsigned WORD_BITS = 8 * ATR_BYTES;
    localparam int unsigned IW        = $clog2(WORD_BITS);

    logic [NUM_LINES-1:0] raw, lvl, rise, fall;
    logic [IW-1:0]        idx;
    logic                 load, step, streaming;

    assign raw[LINE_CRST] = card_rst;
    assign raw[LINE_SEL]  = ~sel_n;
    assign raw[LINE_SCLK] = sclk;
    assign raw[LINE_BUSY] = wr_busy;

    atr_edge_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    atr_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .crst_rise(rise[LINE_CRST]),
        .crst_fall(fall[LINE_CRST]),
        .sel_act  (lvl[LINE_SEL]),
        .sclk_fall(fall[LINE_SCLK]),
        .busy     (lvl[LINE_BUSY]),
        .load     (load),
        .step     (step),
        .streaming(streaming),
        .xact_stop(xact_stop)
    );

    atr_bit_index #(.WORD_BITS(WORD_BITS)) i_index (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .step (step),
        .idx  (idx)
    );

    atr_bit_select #(.BYTES(ATR_BYTES), .WORD(ATR_WORD)) i_select (
        .idx  (idx),
        .en   (streaming),
        .bit_o(sd_out)
    );

    assign sd_oe = streaming;

    // R11
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

    // R4
    out_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && !fall[LINE_SCLK] && !fall[LINE_CRST] && $past(sd_oe)) |=> (!sd_oe || $stable(sd_out)));

endmodule

// File: tb/test_atr_streamer.sv
// Bench: two streamer copies (4-byte and 3-byte words) on shared stimulus.
module test_atr_streamer;

    localparam int          SETTLE = 6;
    localparam int          WA     = 32;
    localparam int          WB     = 24;
    localparam logic [31:0] WORD_A = 32'h55AA0119;
    localparam logic [23:0] WORD_B = 24'h3C81A5;

    logic clk = 1'b0;
    logic rst_n, card_rst, sel_n, sclk, wr_busy;
    logic a_out, a_oe, a_stop, b_out, b_oe, b_stop;
    int   checks = 0, fails = 0, stops_a = 0, stops_b = 0, exp_stops = 0;

    always #2 clk = ~clk;

    atr_streamer i_atr_streamer (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .sel_n(sel_n),
        .sclk(sclk), .wr_busy(wr_busy),
        .sd_out(a_out), .sd_oe(a_oe), .xact_stop(a_stop));

    atr_streamer #(.ATR_BYTES(3), .ATR_WORD(WORD_B)) i_atr_streamer_odd (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .sel_n(sel_n),
        .sclk(sclk), .wr_busy(wr_busy),
        .sd_out(b_out), .sd_oe(b_oe), .xact_stop(b_stop));

    always @(negedge clk) begin
        if (a_stop) stops_a++;
        if (b_stop) stops_b++;
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic pulse_rst();
        card_rst = 1'b1; settle();
        card_rst = 1'b0; settle();
    endtask

    task automatic sclk_cycle();
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
    endtask

    task automatic both_off(input string tag);
        chk({tag, " oe A"}, a_oe, 1'b0);
        chk({tag, " oe B"}, b_oe, 1'b0);
        chk({tag, " out A"}, a_out, 1'b0);
        chk({tag, " out B"}, b_out, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; card_rst = 1'b0; sel_n = 1'b1; sclk = 1'b0; wr_busy = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        both_off("R1 reset");
        chk("R1 stop A", a_stop, 1'b0);
        rst_n = 1'b1; settle();
        both_off("R1 after reset");

        // R4: clocks before arming do nothing
        sel_n = 1'b0; settle();
        sclk_cycle(); sclk_cycle();
        both_off("R4 unarmed clocks");

        // R2 / R9: arm, stay quiet while reset high
        card_rst = 1'b1; settle();
        exp_stops++;
        both_off("R2 reset high");
        chk_int("R9 stop count A", stops_a, exp_stops);
        chk_int("R9 stop count B", stops_b, exp_stops);
        card_rst = 1'b0; settle();
        chk("R2 oe A", a_oe, 1'b1);
        chk("R2 oe B", b_oe, 1'b1);
        chk("R3 bit0 A", a_out, WORD_A[0]);
        chk("R3 bit0 B", b_out, WORD_B[0]);

        // R3 / R4 / R5: walk more than two periods
        for (int n = 1; n <= 2 * WA + 4; n++) begin
            sclk = 1'b1; settle();
            chk("R4 hold on rise A", a_out, WORD_A[(n - 1) % WA]);
            chk("R4 hold on rise B", b_out, WORD_B[(n - 1) % WB]);
            sclk = 1'b0; settle();
            chk("R3 R5 stream A", a_out, WORD_A[n % WA]);
            chk("R3 R5 stream B", b_out, WORD_B[n % WB]);
        end

        // R10: restart mid-stream
        sclk_cycle(); sclk_cycle();
        card_rst = 1'b1; settle();
        exp_stops++;
        both_off("R10 reset high again");
        chk_int("R9 R10 stop count A", stops_a, exp_stops);
        card_rst = 1'b0; settle();
        chk("R10 oe A", a_oe, 1'b1);
        chk("R10 restart bit0 A", a_out, WORD_A[0]);
        chk("R10 restart bit0 B", b_out, WORD_B[0]);
        sclk_cycle();
        chk("R10 bit1 A", a_out, WORD_A[1]);
        chk("R10 bit1 B", b_out, WORD_B[1]);

        // R6 / R11: deselect mid-stream, no resume
        sel_n = 1'b1; settle();
        both_off("R6 R11 deselected");
        sel_n = 1'b0; settle();
        both_off("R6 reselected");
        sclk_cycle();
        both_off("R6 no resume");

        // R6: deselect while armed
        card_rst = 1'b1; settle();
        exp_stops++;
        sel_n = 1'b1; settle();
        card_rst = 1'b0; settle();
        sel_n = 1'b0; settle();
        both_off("R6 armed abort");

        // R7: pulse while deselected
        sel_n = 1'b1; settle();
        pulse_rst();
        sel_n = 1'b0; settle();
        both_off("R7 deselected pulse");
        chk_int("R7 stop count A", stops_a, exp_stops);

        // R8: pulse while busy
        wr_busy = 1'b1; settle();
        pulse_rst();
        both_off("R8 busy pulse");
        chk_int("R8 stop count A", stops_a, exp_stops);
        chk_int("R8 stop count B", stops_b, exp_stops);
        wr_busy = 1'b0; settle();
        both_off("R8 busy released");

        // R8: busy aborts a running stream
        pulse_rst();
        exp_stops++;
        chk("R8 stream up A", a_oe, 1'b1);
        sclk_cycle();
        chk("R8 stream bit1 A", a_out, WORD_A[1]);
        wr_busy = 1'b1; settle();
        both_off("R8 busy abort");
        wr_busy = 1'b0; settle();
        both_off("R8 after busy");
        chk_int("R9 final stop count A", stops_a, exp_stops);
        chk_int("R9 final stop count B", stops_b, exp_stops);

        finish_run();
    end

endmodule